// File: doc/BRIEF.md
# Watchdog Frequency Self-Recovery Controller

This block guards software-driven clock frequency changes. A frequency-select code written by software takes effect at once. If a 4-bit timeout field holds a nonzero value N, that write arms a watchdog that expires after N seconds. A write that only retunes the synthesizer's fine divider also arms it, but does not change the code. Software confirms the change by writing the timeout field back to zero before expiry. The new frequency then stays.

If the watchdog expires, the block does three things. It sets a sticky timeout flag. It falls back to a safe frequency code. It drives an active-low system reset pulse of a fixed number of clock cycles. A revert-mode bit chooses the fallback: either the strap-latched hardware code, or the software code that was written one write before the one that hung the system. A pin-mode bit decides whether the shared pin carries the reset output or serves as a power-down input. In input mode the pin is never driven.

The one-second tick and the reset pulse width are counter parameters. A simulation can therefore use short values, and silicon uses real ones.

Top module: `wdt_freq_recovery`

## Requirements
- R1: After reset, `freq_sel` equals `hw_code`, `tmo_flag` is 0, `sys_rst_n` is 1 and `sys_rst_oe` equals the inverse of `pin_in_mode`.
- R2: A cycle with `sw_code_wr`=1 makes `freq_sel` equal that `sw_code` from the next cycle. A `dial_wr` pulse leaves `freq_sel` unchanged.
- R3: While the timeout field is 0, no write arms the watchdog. `tmo_flag` stays 0 and `sys_rst_n` stays 1, however long the wait.
- R4: With field value N in 1..15, an arming write sampled at clock edge k causes expiry at edge k + N*TICK_CYCLES. At that edge `tmo_flag` becomes 1.
- R5: Writing the field to 0 before expiry cancels the watchdog. No flag and no reset follow, and `freq_sel` keeps the new code.
- R6: `tmo_flag` stays 1 until the field is written with 0. A nonzero field write leaves it set, and a zero write clears it on the next edge.
- R7: On expiry with `revert_sel`=0, `freq_sel` returns to `hw_code`.
- R8: On expiry with `revert_sel`=1, `freq_sel` becomes the software code written one write before the most recent software write. If only one software write has occurred since reset, it becomes `hw_code`.
- R9: In output mode (`pin_in_mode`=0), `sys_rst_n` is 0 for exactly RST_CYCLES cycles, starting in the cycle after the expiry edge.
- R10: In input mode (`pin_in_mode`=1), `sys_rst_oe` is 0 and `sys_rst_n` stays 1 through an expiry. The flag and the frequency revert still happen.
- R11: A software frequency write while the watchdog runs restarts the count. Expiry then falls N*TICK_CYCLES edges after that later write.
- R12: A `dial_wr` pulse with a nonzero field arms the watchdog with the same timing as a frequency write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_code | input | FREQ_W | Strap-latched hardware frequency code |
| sw_code_wr | input | 1 | Software frequency-select write strobe |
| sw_code | input | FREQ_W | Software frequency code to write |
| dial_wr | input | 1 | Fine-divider (dial) write strobe; arms the watchdog only |
| tmo_wr | input | 1 | Timeout field write strobe |
| tmo_val | input | 4 | Timeout field value in seconds; 0 disables |
| revert_sel | input | 1 | Fallback choice: 0 hardware code, 1 previous software code |
| pin_in_mode | input | 1 | 1: shared pin is a power-down input; 0: reset output |
| freq_sel | output | FREQ_W | Frequency code in effect |
| tmo_flag | output | 1 | Sticky watchdog-expired flag |
| sys_rst_n | output | 1 | Active-low system reset value |
| sys_rst_oe | output | 1 | Output enable for the shared reset pin |

## Verification
The timeout is tried with short and long field values, armed by frequency writes and by dial writes. Counting the edges from the arming write to the flag separates an off-by-one tick from a correct N*TICK_CYCLES window. Each revert mode is run with one-deep and two-deep software histories, which tells a hardware fallback from a previous-code fallback. Directed cases cover cancel-before-expiry, restart on a second write, and expiry in input mode, to show that the reset pulse alone is suppressed. Seeded random scenarios mix history depth, field value, revert mode and pin mode.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
   localparam int TMO_W = 4;
   typedef logic [TMO_W-1:0] tmo_t;
   typedef enum logic {
      PIN_RST_OUT = 1'b0,
      PIN_PD_IN   = 1'b1
   } pin_mode_e;
endpackage

// File: rtl/wfr_tick.sv
module wfr_tick #(
   parameter int unsigned TICK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   generate
      if (TICK_CYCLES == 1) begin : g_direct
         assign tick = run;
      end else begin : g_div
         localparam int CW = $clog2(TICK_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (clr || !run)    cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign tick = run && (cnt_q == LAST);

         // R4
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/wfr_timer.sv
module wfr_timer
   import wfr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tmo_wr,
   input  tmo_t tmo_val,
   input  logic start_req,
   input  logic tick,
   output logic running,
   output logic arm,
   output logic expire,
   output logic flag
);
   tmo_t           tmo_q, sec_q;
   logic           cancel;
   logic [TMO_W:0] sec_nx;

   assign cancel = tmo_wr && (tmo_val == '0);
   assign arm    = start_req && (tmo_q != '0);
   assign sec_nx = {1'b0, sec_q} + 1'b1;
   assign expire = running && tick && (sec_nx >= {1'b0, tmo_q})
                   && !start_req && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q   <= '0;
         sec_q   <= '0;
         running <= 1'b0;
         flag    <= 1'b0;
      end else begin
         if (tmo_wr) tmo_q <= tmo_val;
         if (cancel) begin
            running <= 1'b0;
            flag    <= 1'b0;
         end else if (arm) begin
            running <= 1'b1;
            sec_q   <= '0;
         end else if (expire) begin
            running <= 1'b0;
            flag    <= 1'b1;
         end else if (running && tick) begin
            sec_q   <= sec_q + 1'b1;
         end
      end
   end

   // R3
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (tmo_q != '0));
   // R5
   cancel_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> (!running && !flag));
   // R11
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (running && sec_q == '0));
endmodule

// File: rtl/wfr_hist.sv
module wfr_hist #(
   parameter int FREQ_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [FREQ_W-1:0] wr_code,
   input  logic [FREQ_W-1:0] hw_code,
   input  logic              expire,
   input  logic              revert_sel,
   output logic [FREQ_W-1:0] freq_sel
);
   logic [FREQ_W-1:0] cur_q, prev_q;
   logic              cur_v, prev_v, use_sw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
         cur_v  <= 1'b0;
         prev_v <= 1'b0;
         use_sw <= 1'b0;
      end else if (wr) begin
         prev_q <= cur_q;
         cur_q  <= wr_code;
         prev_v <= cur_v;
         cur_v  <= 1'b1;
         use_sw <= 1'b1;
      end else if (expire) begin
         if (revert_sel && prev_v) begin
            cur_q  <= prev_q;
            use_sw <= 1'b1;
         end else begin
            use_sw <= 1'b0;
         end
      end
   end

   assign freq_sel = use_sw ? cur_q : hw_code;

   // R2
   sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (freq_sel == $past(wr_code)));
   // R8
   prev_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && revert_sel && prev_v) |=> (freq_sel == $past(prev_q)));
endmodule

// File: rtl/wfr_pulse.sv
module wfr_pulse
   import wfr_pkg::*;
#(
   parameter int unsigned RST_CYCLES = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      expire,
   input  pin_mode_e pin_mode,
   output logic      sys_rst_n,
   output logic      sys_rst_oe
);
   localparam int CW = $clog2(RST_CYCLES + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (pin_mode == PIN_PD_IN) cnt_q <= '0;
      else if (expire)                cnt_q <= CW'(RST_CYCLES);
      else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
   end

   assign sys_rst_n  = (cnt_q == '0);
   assign sys_rst_oe = (pin_mode == PIN_RST_OUT);

   // R9
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_n) |-> $past(expire));
   // R10
   pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode == PIN_PD_IN) |=> sys_rst_n);
endmodule

// File: rtl/wdt_freq_recovery.sv
module wdt_freq_recovery
   import wfr_pkg::*;
#(
   parameter int          FREQ_W      = 4,
   parameter int unsigned TICK_CYCLES = 50_000_000,
   parameter int unsigned RST_CYCLES  = 300_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] hw_code,
   input  logic              sw_code_wr,
   input  logic [FREQ_W-1:0] sw_code,
   input  logic              dial_wr,
   input  logic              tmo_wr,
   input  logic [3:0]        tmo_val,
   input  logic              revert_sel,
   input  logic              pin_in_mode,
   output logic [FREQ_W-1:0] freq_sel,
   output logic              tmo_flag,
   output logic              sys_rst_n,
   output logic              sys_rst_oe
);
   generate
      if (FREQ_W < 1 || TICK_CYCLES < 1 || RST_CYCLES < 1) begin : g_bad_param
         $error("wdt_freq_recovery: FREQ_W, TICK_CYCLES and RST_CYCLES must be at least 1");
      end
   endgenerate

   logic running, arm, expire, tick;

   wfr_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(arm), .run(running), .tick(tick));

   wfr_timer u_timer (
      .clk(clk), .rst_n(rst_n), .tmo_wr(tmo_wr), .tmo_val(tmo_t'(tmo_val)),
      .start_req(sw_code_wr || dial_wr), .tick(tick), .running(running),
      .arm(arm), .expire(expire), .flag(tmo_flag));

   wfr_hist #(.FREQ_W(FREQ_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .wr(sw_code_wr), .wr_code(sw_code),
      .hw_code(hw_code), .expire(expire), .revert_sel(revert_sel),
      .freq_sel(freq_sel));

   wfr_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
      .clk(clk), .rst_n(rst_n), .expire(expire),
      .pin_mode(pin_in_mode ? PIN_PD_IN : PIN_RST_OUT),
      .sys_rst_n(sys_rst_n), .sys_rst_oe(sys_rst_oe));

   // R7
   hw_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !revert_sel) |=> (freq_sel == $past(hw_code)));
   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag && !(tmo_wr && tmo_val == 4'd0)) |=> tmo_flag);
endmodule

// File: tb/wdt_freq_recovery_test.sv
module wdt_freq_recovery_test;
   localparam int TICK = 5;
   localparam int RSTC = 7;
   localparam logic [3:0] HW = 4'h7;

   logic clk = 0, rst_n = 0;
   logic [3:0] hw_code = HW, sw_code = 0, tmo_val = 0, freq_sel;
   logic sw_code_wr = 0, dial_wr = 0, tmo_wr = 0, revert_sel = 0, pin_in_mode = 0;
   logic tmo_flag, sys_rst_n, sys_rst_oe;

   int compared = 0, mismatched = 0;
   logic [3:0] m_cur = 0, m_prev = 0;
   bit m_curv = 0, m_prevv = 0, m_use = 0;

   always #5 clk = ~clk;

   wdt_freq_recovery #(.FREQ_W(4), .TICK_CYCLES(TICK), .RST_CYCLES(RSTC)) uut (
      .clk(clk), .rst_n(rst_n), .hw_code(hw_code), .sw_code_wr(sw_code_wr),
      .sw_code(sw_code), .dial_wr(dial_wr), .tmo_wr(tmo_wr), .tmo_val(tmo_val),
      .revert_sel(revert_sel), .pin_in_mode(pin_in_mode), .freq_sel(freq_sel),
      .tmo_flag(tmo_flag), .sys_rst_n(sys_rst_n), .sys_rst_oe(sys_rst_oe));

   function automatic logic [3:0] exp_freq();
      return m_use ? m_cur : HW;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic sw_write(input logic [3:0] v);
      @(negedge clk); sw_code_wr = 1; sw_code = v;
      @(negedge clk); sw_code_wr = 0;
      m_prev = m_cur; m_prevv = m_curv; m_cur = v; m_curv = 1; m_use = 1;
   endtask

   task automatic dial_write();
      @(negedge clk); dial_wr = 1;
      @(negedge clk); dial_wr = 0;
   endtask

   task automatic set_tmo(input logic [3:0] v);
      @(negedge clk); tmo_wr = 1; tmo_val = v;
      @(negedge clk); tmo_wr = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // called at the negedge right after the arming write edge
   task automatic wait_expiry(input int n, input string req);
      int cnt = 0;
      int low = 0;
      while (!tmo_flag && cnt < n * TICK + 20) begin
         @(negedge clk); cnt++;
      end
      chk({req, " R4 expiry cycles"}, cnt, n * TICK);
      chk("R4 flag set", tmo_flag, 1);
      if (revert_sel && m_prevv) begin m_cur = m_prev; m_use = 1; end
      else m_use = 0;
      chk(revert_sel ? "R8 revert prev" : "R7 revert hw", freq_sel, exp_freq());
      if (!pin_in_mode) begin
         while (!sys_rst_n && low < 1000) begin low++; @(negedge clk); end
         chk("R9 reset pulse width", low, RSTC);
      end else begin
         for (int i = 0; i < RSTC + 3; i++) begin
            if (!sys_rst_n) low++;
            @(negedge clk);
         end
         chk("R10 no pulse in input mode", low, 0);
         chk("R10 oe low", sys_rst_oe, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL R-watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      idle(3);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 freq", freq_sel, HW);
      chk("R1 flag", tmo_flag, 0);
      chk("R1 rst", sys_rst_n, 1);
      chk("R1 oe", sys_rst_oe, 1);

      // R2 write and dial
      sw_write(4'h3);
      chk("R2 sw write", freq_sel, 4'h3);
      dial_write();
      chk("R2 dial no change", freq_sel, 4'h3);

      // R3 disabled watchdog
      sw_write(4'h9);
      idle(15 * TICK + 10);
      chk("R3 no flag", tmo_flag, 0);
      chk("R3 no reset", sys_rst_n, 1);
      chk("R3 freq kept", freq_sel, 4'h9);

      // R4 / R7 / R9
      revert_sel = 0;
      set_tmo(4'd2);
      sw_write(4'hA);
      wait_expiry(2, "R7");
      // R6
      set_tmo(4'd5);
      chk("R6 nonzero write keeps flag", tmo_flag, 1);
      set_tmo(4'd0);
      chk("R6 zero write clears flag", tmo_flag, 0);

      // R8 with two-deep history
      revert_sel = 1;
      sw_write(4'h1);
      set_tmo(4'd3);
      sw_write(4'hC);
      wait_expiry(3, "R8");
      set_tmo(4'd0);

      // R5 cancel
      set_tmo(4'd3);
      sw_write(4'h5);
      idle(2 * TICK);
      set_tmo(4'd0);
      idle(3 * TICK + 5);
      chk("R5 no flag", tmo_flag, 0);
      chk("R5 freq kept", freq_sel, 4'h5);
      chk("R5 no reset", sys_rst_n, 1);

      // R11 restart
      revert_sel = 0;
      set_tmo(4'd2);
      sw_write(4'h6);
      idle(TICK + 2);
      sw_write(4'hE);
      wait_expiry(2, "R11");
      set_tmo(4'd0);

      // R10 input mode
      @(negedge clk); pin_in_mode = 1;
      @(negedge clk);
      chk("R10 oe off", sys_rst_oe, 0);
      set_tmo(4'd1);
      sw_write(4'h2);
      wait_expiry(1, "R10");
      set_tmo(4'd0);
      @(negedge clk); pin_in_mode = 0;

      // R12 dial arms watchdog
      set_tmo(4'd4);
      dial_write();
      wait_expiry(4, "R12");
      set_tmo(4'd0);

      // seeded random scenarios
      for (int s = 0; s < 24; s++) begin
         int nw = 1 + int'($urandom_range(2));
         int n  = 1 + int'($urandom_range(14));
         for (int w = 0; w < nw; w++) sw_write(4'($urandom_range(15)));
         @(negedge clk);
         revert_sel  = 1'($urandom_range(1));
         pin_in_mode = 1'($urandom_range(1));
         set_tmo(4'(n));
         if ($urandom_range(3) == 0) begin
            dial_write();
            wait_expiry(n, "R12 rnd");
         end else begin
            sw_write(4'($urandom_range(15)));
            wait_expiry(n, revert_sel ? "R8 rnd" : "R7 rnd");
         end
         set_tmo(4'd0);
         chk("R6 rnd clear", tmo_flag, 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule